// File: doc/BRIEF.md
# Acquisition Trigger and Arming Controller

This block decides the cycle in which a data capture begins. It watches three trigger sources: a software request bit, a hardware trigger line, and a cascade line driven by a neighbouring acquisition unit. The cascade line is honoured only while its enable bit is set. Every source is acted upon at its rising edge, taken against one registered copy of the input in the same clock domain. An accepted trigger produces a single-cycle start pulse towards the capture path. A busy indication then holds until the capture path reports that the frame is complete.

Two acquisition modes are offered. In continuous mode every trigger that finds the unit idle starts one frame. In triggered mode a trigger is accepted only while the unit is armed. A rising edge of the arm bit arms the unit, and an accepted trigger disarms it. With auto re-arm set, the unit arms itself again when the running frame completes. Triggers that arrive during a capture are dropped and are not counted.

Sticky status flags record which sources have fired, whether any trigger was accepted, and whether a freeze has occurred. A rising edge of the status-clear bit wipes all of them. A freeze output is raised by the software freeze bit, or by the hardware freeze request when its enable is set; it tells the capture path to discard new data. A counter records every accepted trigger.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: A software request is taken only in the cycle where `sw_trig_bit` goes from 0 to 1. Holding the bit high produces no further request.
- R2: A 0-to-1 change of `arm_bit` sets `armed_o` in the next cycle. A trigger accepted in triggered mode clears `armed_o` in the next cycle, unless an arm edge occurs in the same cycle, in which case the arm edge wins.
- R3: In triggered mode, when `acq_done_i` is high while `busy_o` is high and `auto_rearm_bit` is 1, `armed_o` is 1 in the next cycle. When `auto_rearm_bit` is 0, `armed_o` stays 0 until the next arm edge.
- R4: A rising edge of `casc_trig_i` acts as a trigger and sets `sts_casc_o` only while `casc_en_bit` is 1. Otherwise it has no effect.
- R5: `sts_sw_o`, `sts_casc_o`, `sts_hw_o` and `sts_comb_o` are set by their event: the software edge, the enabled cascade edge, the hardware edge, and an accepted trigger, respectively. Each holds its value until a 0-to-1 change of `clr_status_bit`, which clears all flags in the next cycle and takes priority over a set in the same cycle.
- R6: `freeze_o` equals `sw_freeze_bit` OR (`hw_freeze_req_i` AND `hw_freeze_en_bit`) in the same cycle. `sts_frz_o` is set in the cycle after `freeze_o` is high and is cleared like the R5 flags.
- R7: With `cont_mode_bit` = 1 (continuous), any trigger edge that finds `busy_o` low starts an acquisition, whether or not the unit is armed.
- R8: With `cont_mode_bit` = 0 (triggered), a trigger edge while `armed_o` is 0 starts nothing and is not counted.
- R9: `start_o` is high for exactly one cycle, the cycle after the accepted trigger edge. `busy_o` rises together with it and falls in the cycle after `acq_done_i` is sampled high.
- R10: `trig_count_o` increases by exactly one with each `start_o` pulse and is otherwise unchanged. Reset clears it to 0.
- R11: A trigger edge that arrives while `busy_o` is 1 starts nothing, is not counted and does not disarm the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trig_bit | input | 1 | Software trigger request level |
| hw_trig_i | input | 1 | Hardware trigger line |
| casc_trig_i | input | 1 | Cascade trigger from neighbouring unit |
| arm_bit | input | 1 | Arm control level; its rising edge arms |
| auto_rearm_bit | input | 1 | Re-arm on completion in triggered mode |
| casc_en_bit | input | 1 | Cascade trigger enable |
| cont_mode_bit | input | 1 | 1 = continuous, 0 = triggered |
| sw_freeze_bit | input | 1 | Software freeze |
| hw_freeze_req_i | input | 1 | Hardware freeze request |
| hw_freeze_en_bit | input | 1 | Enable for hardware freeze request |
| clr_status_bit | input | 1 | Status clear level; its rising edge clears |
| acq_done_i | input | 1 | Capture path reports frame complete |
| start_o | output | 1 | One-cycle acquisition start pulse |
| busy_o | output | 1 | Acquisition in progress |
| armed_o | output | 1 | Unit armed for a triggered-mode start |
| freeze_o | output | 1 | Discard-new-data request |
| sts_sw_o | output | 1 | Sticky software-trigger flag |
| sts_casc_o | output | 1 | Sticky cascade-trigger flag |
| sts_hw_o | output | 1 | Sticky hardware-trigger flag |
| sts_comb_o | output | 1 | Sticky accepted-trigger flag |
| sts_frz_o | output | 1 | Sticky freeze-occurred flag |
| trig_count_o | output | CNT_W | Accepted trigger count |

## Verification
The assertions assume that the capture path raises `acq_done_i` only while `busy_o` is high. They also assume that all control levels are synchronous to `clk`, so that an edge is simply a change between two consecutive samples. The random stimulus draws `acq_done_i` only while its own model says a capture is running. Mode and enable bits change rarely, and trigger, arm and clear bits toggle often, so edges regularly land in busy, unarmed and clearing cycles. Directed sequences add the named corners: a request held high, cascade edges while disabled, an unarmed trigger, and re-arm with the auto bit both on and off.

// File: rtl/acqtrig_pkg.sv
package acqtrig_pkg;

  // Indices of the edge-detected control and trigger levels.
  localparam int unsigned EDGE_SW   = 0;
  localparam int unsigned EDGE_HW   = 1;
  localparam int unsigned EDGE_CASC = 2;
  localparam int unsigned EDGE_ARM  = 3;
  localparam int unsigned EDGE_CLR  = 4;
  localparam int unsigned NUM_EDGES = 5;

  // Indices of the sticky status flags.
  localparam int unsigned FLG_SW    = 0;
  localparam int unsigned FLG_CASC  = 1;
  localparam int unsigned FLG_HW    = 2;
  localparam int unsigned FLG_COMB  = 3;
  localparam int unsigned FLG_FRZ   = 4;
  localparam int unsigned NUM_FLAGS = 5;

  typedef struct packed {
    logic sw;
    logic casc;
    logic hw;
  } trig_ev_t;

  function automatic logic rise_of(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic freeze_req(input logic sw_frz, input logic hw_req,
                                      input logic hw_en);
    return sw_frz | (hw_req & hw_en);
  endfunction

  function automatic logic any_event(input trig_ev_t ev);
    return ev.sw | ev.casc | ev.hw;
  endfunction

  // Whether an event in this cycle may start a frame.
  function automatic logic may_start(input logic ev, input logic busy,
                                     input logic cont, input logic armed);
    return ev & ~busy & (cont | armed);
  endfunction

endpackage

// File: rtl/acqtrig_edge.sv
module acqtrig_edge #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  import acqtrig_pkg::*;

  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = rise_of(lvl_i[i], prev_q[i]);
  end

endmodule

// File: rtl/acqtrig_flags.sv
module acqtrig_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (clr_i)    flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/acqtrig_seq.sv
module acqtrig_seq
  import acqtrig_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trig_ev_t         ev_i,
  input  logic             arm_rise_i,
  input  logic             auto_rearm_i,
  input  logic             cont_mode_i,
  input  logic             acq_done_i,
  output logic             valid_o,
  output logic             start_o,
  output logic             busy_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] count_o
);

  logic             start_q, busy_q, armed_q;
  logic [CNT_W-1:0] count_q;
  logic             trig_ok, rearm;

  always_comb begin
    trig_ok = may_start(any_event(ev_i), busy_q, cont_mode_i, armed_q);
    rearm   = acq_done_i & busy_q & auto_rearm_i & ~cont_mode_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      armed_q <= 1'b0;
      count_q <= '0;
    end else begin
      start_q <= trig_ok;
      if (trig_ok)         busy_q <= 1'b1;
      else if (acq_done_i) busy_q <= 1'b0;
      if (arm_rise_i)                    armed_q <= 1'b1;
      else if (trig_ok && !cont_mode_i)  armed_q <= 1'b0;
      else if (rearm)                    armed_q <= 1'b1;
      if (trig_ok) count_q <= count_q + 1'b1;
    end
  end

  assign valid_o = trig_ok;
  assign start_o = start_q;
  assign busy_o  = busy_q;
  assign armed_o = armed_q;
  assign count_o = count_q;

endmodule

// File: rtl/acq_trigger_ctrl.sv
module acq_trigger_ctrl
  import acqtrig_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_trig_bit,
  input  logic             hw_trig_i,
  input  logic             casc_trig_i,
  input  logic             arm_bit,
  input  logic             auto_rearm_bit,
  input  logic             casc_en_bit,
  input  logic             cont_mode_bit,
  input  logic             sw_freeze_bit,
  input  logic             hw_freeze_req_i,
  input  logic             hw_freeze_en_bit,
  input  logic             clr_status_bit,
  input  logic             acq_done_i,
  output logic             start_o,
  output logic             busy_o,
  output logic             armed_o,
  output logic             freeze_o,
  output logic             sts_sw_o,
  output logic             sts_casc_o,
  output logic             sts_hw_o,
  output logic             sts_comb_o,
  output logic             sts_frz_o,
  output logic [CNT_W-1:0] trig_count_o
);

  logic [NUM_EDGES-1:0] lvl, rises;
  logic [NUM_FLAGS-1:0] flag_set, flags;
  trig_ev_t             trig_ev;
  logic                 arm_rise, clr_rise, trig_valid;

  always_comb begin
    lvl            = '0;
    lvl[EDGE_SW]   = sw_trig_bit;
    lvl[EDGE_HW]   = hw_trig_i;
    lvl[EDGE_CASC] = casc_trig_i;
    lvl[EDGE_ARM]  = arm_bit;
    lvl[EDGE_CLR]  = clr_status_bit;
  end

  acqtrig_edge #(.N(NUM_EDGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .rise_o (rises)
  );

  always_comb begin
    trig_ev.sw   = rises[EDGE_SW];
    trig_ev.hw   = rises[EDGE_HW];
    trig_ev.casc = rises[EDGE_CASC] & casc_en_bit;
    arm_rise     = rises[EDGE_ARM];
    clr_rise     = rises[EDGE_CLR];
    freeze_o     = freeze_req(sw_freeze_bit, hw_freeze_req_i, hw_freeze_en_bit);
  end

  acqtrig_seq #(.CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_i         (trig_ev),
    .arm_rise_i   (arm_rise),
    .auto_rearm_i (auto_rearm_bit),
    .cont_mode_i  (cont_mode_bit),
    .acq_done_i   (acq_done_i),
    .valid_o      (trig_valid),
    .start_o      (start_o),
    .busy_o       (busy_o),
    .armed_o      (armed_o),
    .count_o      (trig_count_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_SW]   = trig_ev.sw;
    flag_set[FLG_CASC] = trig_ev.casc;
    flag_set[FLG_HW]   = trig_ev.hw;
    flag_set[FLG_COMB] = trig_valid;
    flag_set[FLG_FRZ]  = freeze_o;
  end

  acqtrig_flags #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (clr_rise),
    .flag_o (flags)
  );

  assign sts_sw_o   = flags[FLG_SW];
  assign sts_casc_o = flags[FLG_CASC];
  assign sts_hw_o   = flags[FLG_HW];
  assign sts_comb_o = flags[FLG_COMB];
  assign sts_frz_o  = flags[FLG_FRZ];

endmodule

// File: rtl/acqtrig_checker.sv
module acqtrig_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             auto_rearm_bit,
  input logic             casc_en_bit,
  input logic             cont_mode_bit,
  input logic             acq_done_i,
  input logic             start_o,
  input logic             busy_o,
  input logic             armed_o,
  input logic             freeze_o,
  input logic             sts_sw_o,
  input logic             sts_casc_o,
  input logic             sts_frz_o,
  input logic [CNT_W-1:0] trig_count_o,
  input logic             arm_rise,
  input logic             clr_rise,
  input logic             trig_valid
);

  p_armed_consumed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && !cont_mode_bit && !arm_rise |=> !armed_o);

  p_auto_rearm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && acq_done_i && auto_rearm_bit && !cont_mode_bit |=> armed_o);

  p_cascade_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_casc_o) |-> $past(casc_en_bit));

  p_sticky_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sts_sw_o && !clr_rise |=> sts_sw_o);

  p_freeze_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o && !clr_rise |=> sts_frz_o);

  p_armed_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && !$past(cont_mode_bit) |-> $past(armed_o));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> trig_count_o == ($past(trig_count_o) + 1'b1));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |-> $stable(trig_count_o));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !start_o);

endmodule

bind acq_trigger_ctrl acqtrig_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .auto_rearm_bit (auto_rearm_bit),
  .casc_en_bit    (casc_en_bit),
  .cont_mode_bit  (cont_mode_bit),
  .acq_done_i     (acq_done_i),
  .start_o        (start_o),
  .busy_o         (busy_o),
  .armed_o        (armed_o),
  .freeze_o       (freeze_o),
  .sts_sw_o       (sts_sw_o),
  .sts_casc_o     (sts_casc_o),
  .sts_frz_o      (sts_frz_o),
  .trig_count_o   (trig_count_o),
  .arm_rise       (arm_rise),
  .clr_rise       (clr_rise),
  .trig_valid     (trig_valid)
);

// File: tb/acq_trigger_ctrl_test.sv
module acq_trigger_ctrl_test;

  localparam int unsigned CW = 32;
  // Stimulus vector bit positions
  localparam int B_SW = 0, B_HW = 1, B_CS = 2, B_ARM = 3, B_AUTO = 4, B_CSEN = 5,
                 B_CONT = 6, B_SWF = 7, B_HWFR = 8, B_HWFE = 9, B_CLR = 10, B_DONE = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] cur = '0;

  logic start_o, busy_o, armed_o, freeze_o;
  logic sts_sw_o, sts_casc_o, sts_hw_o, sts_comb_o, sts_frz_o;
  logic [CW-1:0] trig_count_o;

  int n_chk = 0;
  int n_bad = 0;

  // Bench reference state
  logic [11:0] m_prev = '0;
  logic m_start = 0, m_busy = 0, m_armed = 0;
  logic [4:0] m_flag = '0;
  logic [CW-1:0] m_cnt = '0;
  logic m_frz = 0;

  always #5 clk = ~clk;

  acq_trigger_ctrl #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .sw_trig_bit(cur[B_SW]), .hw_trig_i(cur[B_HW]), .casc_trig_i(cur[B_CS]),
    .arm_bit(cur[B_ARM]), .auto_rearm_bit(cur[B_AUTO]), .casc_en_bit(cur[B_CSEN]),
    .cont_mode_bit(cur[B_CONT]), .sw_freeze_bit(cur[B_SWF]),
    .hw_freeze_req_i(cur[B_HWFR]), .hw_freeze_en_bit(cur[B_HWFE]),
    .clr_status_bit(cur[B_CLR]), .acq_done_i(cur[B_DONE]),
    .start_o(start_o), .busy_o(busy_o), .armed_o(armed_o), .freeze_o(freeze_o),
    .sts_sw_o(sts_sw_o), .sts_casc_o(sts_casc_o), .sts_hw_o(sts_hw_o),
    .sts_comb_o(sts_comb_o), .sts_frz_o(sts_frz_o), .trig_count_o(trig_count_o)
  );

  task automatic chk(input logic ok, input string req, input logic [CW-1:0] act,
                     input logic [CW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic edge_of(input logic [11:0] v, input logic [11:0] p, input int b);
    return v[b] && !p[b];
  endfunction

  // One clock: drive v after the falling edge, predict, compare after the rising edge.
  task automatic cyc(input logic [11:0] v);
    logic s, h, c, a, cl, any, ok;
    @(negedge clk);
    cur = v;
    #1;
    m_frz = v[B_SWF] || (v[B_HWFR] && v[B_HWFE]);
    chk(freeze_o == m_frz, "R6 freeze", freeze_o, m_frz);
    s  = edge_of(v, m_prev, B_SW);
    h  = edge_of(v, m_prev, B_HW);
    c  = edge_of(v, m_prev, B_CS) && v[B_CSEN];
    a  = edge_of(v, m_prev, B_ARM);
    cl = edge_of(v, m_prev, B_CLR);
    any = s || h || c;
    ok  = any && !m_busy && (v[B_CONT] || m_armed);
    if (a) m_armed = 1;
    else if (ok && !v[B_CONT]) m_armed = 0;
    else if (v[B_DONE] && m_busy && v[B_AUTO] && !v[B_CONT]) m_armed = 1;
    if (ok) m_busy = 1; else if (v[B_DONE]) m_busy = 0;
    m_start = ok;
    if (ok) m_cnt = m_cnt + 1;
    if (cl) m_flag = '0;
    else m_flag = m_flag | {m_frz, ok, h, c, s};
    m_prev = v;
    @(posedge clk);
    #1;
    chk(start_o == m_start, "R9 start", start_o, m_start);
    chk(busy_o == m_busy, "R9 busy", busy_o, m_busy);
    chk(armed_o == m_armed, "R2 armed", armed_o, m_armed);
    chk(trig_count_o == m_cnt, "R10 count", trig_count_o, m_cnt);
    chk({sts_frz_o, sts_comb_o, sts_hw_o, sts_casc_o, sts_sw_o} == m_flag,
        "R5 flags", {sts_frz_o, sts_comb_o, sts_hw_o, sts_casc_o, sts_sw_o}, m_flag);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [CW-1:0] c0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk({start_o, busy_o, armed_o, sts_sw_o, sts_casc_o, sts_hw_o, sts_comb_o, sts_frz_o} == 0,
        "R9 reset state", {start_o, busy_o, armed_o}, 0);
    chk(trig_count_o == 0, "R10 reset count", trig_count_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: continuous mode start without arming
    cur = '0; cur[B_CONT] = 1; cyc(cur);
    cur[B_SW] = 1; cyc(cur);
    chk(start_o == 1, "R7 continuous start", start_o, 1);
    // R1: held request makes no new start after completion
    cur[B_DONE] = 1; cyc(cur); cur[B_DONE] = 0;
    cyc(cur); cyc(cur);
    chk(start_o == 0 && busy_o == 0, "R1 held request ignored", start_o, 0);
    cur[B_SW] = 0; cyc(cur);

    // R11: edge while busy ignored
    cur[B_HW] = 1; cyc(cur);
    c0 = trig_count_o;
    cur[B_SW] = 1; cyc(cur);
    chk(start_o == 0 && trig_count_o == c0, "R11 busy ignore", trig_count_o, c0);
    cur[B_DONE] = 1; cyc(cur); cur[B_DONE] = 0;
    cur[B_SW] = 0; cur[B_HW] = 0; cyc(cur);

    // R4: cascade disabled then enabled
    cur[B_CS] = 1; cyc(cur);
    chk(start_o == 0 && sts_casc_o == 0, "R4 cascade disabled", sts_casc_o, 0);
    cur[B_CS] = 0; cur[B_CSEN] = 1; cyc(cur);
    cur[B_CS] = 1; cyc(cur);
    chk(start_o == 1 && sts_casc_o == 1, "R4 cascade enabled", sts_casc_o, 1);
    cur[B_CS] = 0; cur[B_DONE] = 1; cyc(cur); cur[B_DONE] = 0;

    // R8: triggered mode, unarmed trigger ignored
    cur[B_CONT] = 0; cyc(cur);
    c0 = trig_count_o;
    cur[B_HW] = 1; cyc(cur);
    chk(start_o == 0 && trig_count_o == c0, "R8 unarmed ignored", trig_count_o, c0);
    cur[B_HW] = 0; cyc(cur);

    // R2: arm edge then trigger consumes arming
    cur[B_ARM] = 1; cyc(cur);
    chk(armed_o == 1, "R2 arm edge", armed_o, 1);
    cur[B_HW] = 1; cyc(cur);
    chk(start_o == 1 && armed_o == 0, "R2 disarm on start", armed_o, 0);
    // R3: auto re-arm off keeps disarmed after completion
    cur[B_HW] = 0; cur[B_DONE] = 1; cyc(cur); cur[B_DONE] = 0; cyc(cur);
    chk(armed_o == 0, "R3 no auto rearm", armed_o, 0);
    // R3: auto re-arm on
    cur[B_ARM] = 0; cyc(cur); cur[B_ARM] = 1; cyc(cur);
    cur[B_AUTO] = 1; cur[B_SW] = 1; cyc(cur);
    cur[B_SW] = 0; cur[B_DONE] = 1; cyc(cur); cur[B_DONE] = 0;
    chk(armed_o == 1, "R3 auto rearm", armed_o, 1);

    // R5/R6: freeze flag and clear edge
    cur[B_HWFR] = 1; cur[B_HWFE] = 1; cyc(cur);
    chk(sts_frz_o == 1, "R6 freeze sticky", sts_frz_o, 1);
    cur[B_HWFR] = 0; cur[B_CLR] = 1; cyc(cur);
    chk({sts_sw_o, sts_casc_o, sts_hw_o, sts_comb_o, sts_frz_o} == 0, "R5 clear edge",
        {sts_sw_o, sts_casc_o, sts_hw_o, sts_comb_o, sts_frz_o}, 0);
    cur[B_CLR] = 0; cyc(cur);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] v;
      v = cur;
      v[B_SW]  = ($urandom % 3) == 0;
      v[B_HW]  = ($urandom % 3) == 0;
      v[B_CS]  = ($urandom % 3) == 0;
      v[B_ARM] = ($urandom % 4) == 0;
      v[B_CLR] = ($urandom % 8) == 0;
      v[B_SWF] = ($urandom % 10) == 0;
      v[B_HWFR] = ($urandom % 5) == 0;
      if (($urandom % 20) == 0) v[B_AUTO] = ~v[B_AUTO];
      if (($urandom % 20) == 0) v[B_CSEN] = ~v[B_CSEN];
      if (($urandom % 25) == 0) v[B_CONT] = ~v[B_CONT];
      if (($urandom % 15) == 0) v[B_HWFE] = ~v[B_HWFE];
      v[B_DONE] = m_busy && (($urandom % 4) == 0);
      cyc(v);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule